// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from on-chip peripherals and presents one interrupt line to the processor. Each peripheral pulses its bit of a request vector. The pulse latches into a pending status register. A separate enable mask decides which pending bits may raise the processor interrupt. Software reaches both registers through a small register bus that carries 16-bit and 32-bit accesses.

Software acknowledges a pending bit by writing the status register. A status write can only clear bits: the new status is the old status ANDed with the mask and with the written value. A zero in the written value therefore acknowledges that bit, and a write can never set a bit. A mask write stores the written value unchanged. If the new mask exposes bits that are already pending, the block raises a one-cycle re-check pulse so that the processor looks at its interrupt state again without delay.

The bus is a plain, single-cycle register port with no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_we` are both high, and read data is combinational from the address. Source bit 3 carries the DMA request, bit 7 the serial port and bit 9 the sound unit. The other source bits are free for general use.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the status register, the mask register, `irq_out` and `recheck` are all zero.
- R2: A high bit of `src_req` sets the same status bit at the next clock edge, whatever the mask holds. Index 3 is DMA, index 7 is the serial port and index 9 is the sound unit.
- R3: A write at offset 0x070 replaces status with status AND mask AND the written value, so a written 0 clears that bit and a written 1 keeps it only if the bit is enabled.
- R4: A `src_req` bit that is high in the same cycle as an acknowledging status write keeps its status bit set.
- R5: A write at offset 0x074 stores bits [10:0] of the written value into the mask unchanged.
- R6: `recheck` is high for exactly the cycle after a mask write whose value, ANDed with the status held at that write, is non-zero. It is low in every other cycle.
- R7: `irq_out` is a register. After every clock edge it equals the OR of (status AND mask) as held after that edge.
- R8: `bus_wide`=1 selects a 32-bit access and `bus_wide`=0 a 16-bit access, which uses only `bus_wdata[15:0]`. Writes of both widths have the same effect on the 11-bit registers.
- R9: With `bus_sel` high, a read returns the addressed register zero-extended, with bits [31:11] zero; a 16-bit read also returns zero in bits [31:16]. Any other offset reads as zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 12 | Byte offset within the I/O window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_req | input | 11 | Request pulses from the interrupt sources |
| irq_out | output | 1 | Interrupt line to the processor |
| recheck | output | 1 | One-cycle re-check pulse after a mask write that exposes pending bits |

## Verification
The bench drives a source request and an acknowledging write to the same bit in one cycle. A design that let the write win would lose that interrupt for good. It writes status with all ones while some mask bits are zero. A design that ignored the mask term would leave disabled bits pending, and a design that ORed in the written value would set bits that no source raised. It writes a mask that exposes bits already pending and checks for the pulse one cycle later. It also writes a mask that exposes nothing and checks that no pulse appears. Finally it writes to an offset that maps to neither register and reads the registers back. A decoder that ignored the upper address bits would corrupt a register there or return stale data.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned SRC_DMA    = 3;
  localparam int unsigned SRC_SERIAL = 7;
  localparam int unsigned SRC_SOUND  = 9;

  typedef enum logic {
    ACC_HALF = 1'b0,
    ACC_WORD = 1'b1
  } acc_width_e;
endpackage

// File: rtl/irq_ctrl_decode.sv
module irq_ctrl_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_SRC  = 11,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
  input  logic               sel,
  input  logic               we,
  input  logic               wide,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic               stat_hit,
  output logic               mask_hit,
  output logic               stat_wr,
  output logic               mask_wr,
  output logic [NUM_SRC-1:0] wval
);
  import irq_ctrl_pkg::*;
  localparam logic [31:0] HALF_KEEP = 32'h0000_FFFF;

  logic [31:0] wval32;

  always_comb begin
    stat_hit = sel && (addr == STAT_OFS);
    mask_hit = sel && (addr == MASK_OFS);
    stat_wr  = stat_hit && we;
    mask_wr  = mask_hit && we;
    wval32   = (acc_width_e'(wide) == ACC_WORD) ? wdata : (wdata & HALF_KEEP);
    wval     = wval32[NUM_SRC-1:0];
  end
endmodule

// File: rtl/irq_ctrl_status.sv
module irq_ctrl_status #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_wr,
  input  logic [NUM_SRC-1:0] ack_val,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] src_req,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] status_d
);
  logic [NUM_SRC-1:0] kept;

  always_comb begin
    kept     = ack_wr ? (status_q & mask_q & ack_val) : status_q;
    status_d = kept | src_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> ((status_q & $past(src_req)) == $past(src_req))); // R2

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && src_req == '0) |=> (status_q == $past(status_q & mask_q & ack_val))); // R3

  AST_ACK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((status_q & ~$past(status_q) & ~$past(src_req)) == '0)); // R4
endmodule

// File: rtl/irq_ctrl_mask.sv
module irq_ctrl_mask #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [NUM_SRC-1:0] wval,
  input  logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_d,
  output logic               recheck
);
  always_comb mask_d = wr ? wval : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      recheck <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      recheck <= wr && ((status_q & wval) != '0);
    end
  end

  AST_MASK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mask_q == $past(wval))); // R5

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask_q)); // R5

  AST_RECHECK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !recheck); // R6
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_SRC = 11,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic               bus_wide,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic               irq_out,
  output logic               recheck
);
  localparam logic [31:0] HALF_KEEP = 32'h0000_FFFF;

  logic               stat_hit, mask_hit, stat_wr, mask_wr;
  logic [NUM_SRC-1:0] wval;
  logic [NUM_SRC-1:0] status_q, status_d, mask_q, mask_d;
  logic [31:0]        rd_sel;

  irq_ctrl_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
  ) u_decode (
    .sel(bus_sel), .we(bus_we), .wide(bus_wide), .addr(bus_addr), .wdata(bus_wdata),
    .stat_hit(stat_hit), .mask_hit(mask_hit), .stat_wr(stat_wr), .mask_wr(mask_wr),
    .wval(wval)
  );

  irq_ctrl_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .ack_wr(stat_wr), .ack_val(wval), .mask_q(mask_q),
    .src_req(src_req), .status_q(status_q), .status_d(status_d)
  );

  irq_ctrl_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wval(wval), .status_q(status_q),
    .mask_q(mask_q), .mask_d(mask_d), .recheck(recheck)
  );

  // Registered line computed from next state, so it lines up with the registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |(status_d & mask_d);
  end

  always_comb begin
    rd_sel = '0;
    if (stat_hit)      rd_sel = 32'(status_q);
    else if (mask_hit) rd_sel = 32'(mask_q);
    bus_rdata = bus_wide ? rd_sel : (rd_sel & HALF_KEEP);
  end

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(status_q & mask_q)); // R7

  AST_RECHECK_EXPOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && ((status_q & wval) != '0)) |=> recheck); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:NUM_SRC] == '0); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!irq_out && !recheck)); // R1
endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_we = 0, bus_wide = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] src_req = '0;
  logic        irq_out, recheck;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [NS-1:0] m_stat = '0, m_mask = '0;
  logic          m_rc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_req(src_req), .irq_out(irq_out), .recheck(recheck)
  );

  function automatic logic [NS-1:0] eff_val(input logic wide, input logic [31:0] d);
    logic [31:0] t;
    t = wide ? d : (d & 32'h0000_FFFF);
    return t[NS-1:0];
  endfunction

  function automatic logic [31:0] exp_read(input logic wide, input logic [11:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 12'h070) r = 32'(m_stat);
    else if (a == 12'h074) r = 32'(m_mask);
    return wide ? r : (r & 32'h0000_FFFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check read data, clock, then check outputs.
  task automatic cyc(input logic sel, input logic we, input logic wide,
                     input logic [11:0] a, input logic [31:0] d, input logic [NS-1:0] src,
                     input string tag);
    logic [NS-1:0] v;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_wide = wide; bus_addr = a; bus_wdata = d; src_req = src;
    #1;
    if (sel && !we) check({tag, " R9 read"}, bus_rdata, exp_read(wide, a));
    v = eff_val(wide, d);
    m_rc = sel && we && a == 12'h074 && ((m_stat & v) != '0);
    if (sel && we && a == 12'h070) m_stat = m_stat & m_mask & v;
    if (sel && we && a == 12'h074) m_mask = v;
    m_stat = m_stat | src;
    @(posedge clk);
    #1;
    check({tag, " R7 irq"}, 32'(irq_out), 32'(|(m_stat & m_mask)));
    check({tag, " R6 recheck"}, 32'(recheck), 32'(m_rc));
    bus_sel = 0; bus_we = 0; src_req = '0;
  endtask

  task automatic rd_both(input string tag);
    cyc(1, 0, 1, 12'h070, 32'hFFFF_FFFF, '0, tag);
    cyc(1, 0, 1, 12'h074, 32'hFFFF_FFFF, '0, tag);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq reset", 32'(irq_out), 32'd0);
    check("R1 recheck reset", 32'(recheck), 32'd0);
    check("R1 status reset", bus_rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    rd_both("R1");

    // R2: each named source sets its bit with mask zero, no irq
    cyc(0, 0, 0, 12'h000, 0, NS'(1 << 3), "R2 dma");
    cyc(0, 0, 0, 12'h000, 0, NS'(1 << 7), "R2 serial");
    cyc(0, 0, 0, 12'h000, 0, NS'(1 << 9), "R2 sound");
    rd_both("R2");

    // R6: mask exposing pending bit 7 pulses; then one exposing nothing does not
    cyc(1, 1, 1, 12'h074, 32'h0000_0080, '0, "R5 R6 expose");
    cyc(1, 1, 0, 12'h074, 32'h0000_0001, '0, "R6 no expose");
    cyc(1, 1, 1, 12'h074, 32'h0000_0288, '0, "R5 mask");
    rd_both("R5");

    // R3: write all ones while mask lacks bit 0; R4 collision on bit 9
    cyc(0, 0, 0, 12'h000, 0, NS'(1), "R2 bit0");
    cyc(1, 1, 1, 12'h070, 32'hFFFF_FFFF, '0, "R3 keep enabled");
    rd_both("R3");
    cyc(1, 1, 0, 12'h070, 32'h0000_0000, NS'(1 << 9), "R4 collide");
    rd_both("R4");

    // R8: 16-bit write ignores upper half; R9 stray offset ignored
    cyc(1, 1, 0, 12'h074, 32'h07FF_0004, '0, "R8 half mask");
    rd_both("R8");
    cyc(1, 1, 1, 12'h078, 32'hFFFF_FFFF, '0, "R9 stray write");
    cyc(1, 1, 1, 12'h470, 32'h0000_0000, '0, "R9 alias write");
    cyc(1, 0, 1, 12'h078, 0, '0, "R9 stray read");
    rd_both("R9");

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      case ($urandom_range(0, 3))
        0: a = 12'h070;
        1: a = 12'h074;
        2: a = 12'h078;
        default: a = 12'h000;
      endcase
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          a, $urandom(), ($urandom_range(0, 3) == 0) ? NS'($urandom()) : '0, "R3 R5 random");
    end
    rd_both("R9 final");

    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 irq re-reset", 32'(irq_out), 32'd0);
    m_stat = '0; m_mask = '0;
    @(negedge clk); rst_n = 1'b1;
    rd_both("R1 after");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule